// File: doc/BRIEF.md
# Packed SIMD Integer ALU

A single-cycle integer arithmetic unit that operates on one pair of 32-bit sources. A lane-mode select makes it treat each source as one 32-bit value, two 16-bit halves or four bytes. Every lane is computed on its own: carries never cross a lane edge, and saturation clamps each lane to that lane's own signed limits.

The unit offers wrapping and saturating add and subtract, and a paired operation that returns the sum on one result port and the difference on the other from the same inputs. It also has per-lane signed minimum and maximum, widening of two bytes into two 16-bit lanes, and narrowing of four 16-bit values into four bytes with optional saturation. An operation is accepted in a cycle where `inValid` is high. Its results are registered and appear on the next clock edge together with `outValid`.

Top module: `simd_alu`

## Requirements
- R1: While `rstN` is low, `outValid`, `resA` and `resB` are all zero.
- R2: `outValid` is high exactly one cycle after a cycle with `inValid` high, and low otherwise. `resA` and `resB` hold their values while `inValid` is low.
- R3: Opcode 0 (add) and opcode 1 (subtract, A minus B) wrap modulo the lane width. `laneMode` 0 gives one 32-bit lane, 1 gives two 16-bit lanes (bits 15:0 and 31:16), and 2 gives four 8-bit lanes. No carry or borrow passes between lanes.
- R4: Opcode 2 (add) and opcode 3 (subtract) saturate each signed lane. Limits are 0x7F/0x80 for 8-bit lanes, 0x7FFF/0x8000 for 16-bit lanes and 0x7FFFFFFF/0x80000000 for the 32-bit lane.
- R5: Opcode 4 puts the per-lane wrapping sum A+B on `resA` and the per-lane wrapping difference A−B on `resB`. Opcode 5 does the same with saturation. For every other opcode, `resB` is zero.
- R6: Opcode 6 gives the per-lane signed minimum of A and B, and opcode 7 gives the per-lane signed maximum.
- R7: Opcodes 8 to 11 widen two bytes of A into two 16-bit lanes. Byte A[7:0] (or A[23:16]) goes to `resA[15:0]`, and byte A[15:8] (or A[31:24]) goes to `resA[31:16]`. Opcode 8 takes the low two bytes and zero-extends. Opcode 9 takes the high two bytes and zero-extends. Opcode 10 takes the low two bytes and sign-extends. Opcode 11 takes the high two bytes and sign-extends. `laneMode` is ignored.
- R8: Opcodes 12 and 13 narrow four 16-bit values into four bytes of `resA`. A[15:0] goes to byte 0, A[31:16] to byte 1, B[15:0] to byte 2 and B[31:16] to byte 3. Opcode 12 keeps the low byte of each value. Opcode 13 clamps each signed value to 0x7F/0x80. `laneMode` is ignored.
- R9: Opcodes 14 and 15 give zero on `resA` and `resB`. `laneMode` 3 behaves as one 32-bit lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation accepted this cycle |
| opCode | input | 4 | Operation select |
| laneMode | input | 2 | Lane partition select |
| srcA | input | 32 | First source |
| srcB | input | 32 | Second source |
| outValid | output | 1 | Results updated on this cycle |
| resA | output | 32 | Primary result |
| resB | output | 32 | Difference of the paired operation, otherwise zero |

## Verification
Every opcode is tried in every lane mode over a cross product of edge words: all-zero, all-ones, and lane-wise maximum and minimum signed values. Carry propagation and saturation can only be told apart at those values. A stride sweep of byte values with a different pattern in each byte separates a carry that leaks across a byte edge from a correctly cut one. Pseudo-random words, which mix lane signs, expose a min/max compare or a saturation direction taken from the wrong lane. Idle cycles between operations show that `outValid` drops and that the registered results hold.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int DataW = 32;
  localparam int ByteW = 8;
  localparam int NumBytes = DataW / ByteW;
  localparam int HalfW = DataW / 2;

  typedef enum logic [3:0] {
    OP_ADD        = 4'd0,
    OP_SUB        = 4'd1,
    OP_ADD_SAT    = 4'd2,
    OP_SUB_SAT    = 4'd3,
    OP_ADDSUB     = 4'd4,
    OP_ADDSUB_SAT = 4'd5,
    OP_MIN        = 4'd6,
    OP_MAX        = 4'd7,
    OP_WIDEN_LO_U = 4'd8,
    OP_WIDEN_HI_U = 4'd9,
    OP_WIDEN_LO_S = 4'd10,
    OP_WIDEN_HI_S = 4'd11,
    OP_NARROW     = 4'd12,
    OP_NARROW_SAT = 4'd13
  } aluOpT;

  typedef enum logic [1:0] {
    LANES_1X32 = 2'd0,
    LANES_2X16 = 2'd1,
    LANES_4X8  = 2'd2,
    LANES_RSVD = 2'd3
  } laneModeT;

  typedef struct packed {
    logic cut16;
    logic cut8;
    logic arith;
    logic doSub;
    logic doSat;
    logic pair;
    logic doMin;
    logic doMax;
    logic unpack;
    logic unpackHigh;
    logic unpackSigned;
    logic pack;
    logic packSat;
  } ctrlT;
endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] opCode,
  input  logic [1:0] laneMode,
  output ctrlT       ctl,
  output logic       outValid
);
  always_comb begin
    ctl = '0;
    ctl.cut8  = (laneMode == LANES_4X8);
    ctl.cut16 = (laneMode == LANES_2X16) || (laneMode == LANES_4X8);
    case (opCode)
      OP_ADD:        ctl.arith = 1'b1;
      OP_SUB:        begin ctl.arith = 1'b1; ctl.doSub = 1'b1; end
      OP_ADD_SAT:    begin ctl.arith = 1'b1; ctl.doSat = 1'b1; end
      OP_SUB_SAT:    begin ctl.arith = 1'b1; ctl.doSub = 1'b1; ctl.doSat = 1'b1; end
      OP_ADDSUB:     ctl.pair = 1'b1;
      OP_ADDSUB_SAT: begin ctl.pair = 1'b1; ctl.doSat = 1'b1; end
      OP_MIN:        ctl.doMin = 1'b1;
      OP_MAX:        ctl.doMax = 1'b1;
      OP_WIDEN_LO_U: ctl.unpack = 1'b1;
      OP_WIDEN_HI_U: begin ctl.unpack = 1'b1; ctl.unpackHigh = 1'b1; end
      OP_WIDEN_LO_S: begin ctl.unpack = 1'b1; ctl.unpackSigned = 1'b1; end
      OP_WIDEN_HI_S: begin ctl.unpack = 1'b1; ctl.unpackHigh = 1'b1; ctl.unpackSigned = 1'b1; end
      OP_NARROW:     ctl.pack = 1'b1;
      OP_NARROW_SAT: begin ctl.pack = 1'b1; ctl.packSat = 1'b1; end
      default:       ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/simd_alu_dp.sv
module simd_alu_dp
  import simd_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  ctrlT             ctl,
  input  logic [DataW-1:0] srcA,
  input  logic [DataW-1:0] srcB,
  output logic [DataW-1:0] resA,
  output logic [DataW-1:0] resB
);
  // Top byte index of the lane that byte i belongs to.
  function automatic int laneTop(int i, logic c16, logic c8);
    if (c8)  return i;
    if (c16) return i | 1;
    return NumBytes - 1;
  endfunction

  function automatic logic laneStart(int i, logic c16, logic c8);
    if (i == 0) return 1'b1;
    if (i == NumBytes / 2) return c16;
    return c8;
  endfunction

  function automatic logic [DataW-1:0] laneAdd(
    input logic [DataW-1:0] a, input logic [DataW-1:0] b, input logic sub,
    input logic c16, input logic c8, output logic [NumBytes-1:0] ovf);
    logic [DataW-1:0] bb;
    logic [DataW-1:0] r;
    logic [ByteW:0] t;
    logic c;
    bb = sub ? ~b : b;
    c = sub;
    r = '0;
    for (int i = 0; i < NumBytes; i++) begin
      if (laneStart(i, c16, c8)) c = sub;
      t = {1'b0, a[ByteW*i +: ByteW]} + {1'b0, bb[ByteW*i +: ByteW]} + (ByteW+1)'(c);
      r[ByteW*i +: ByteW] = t[ByteW-1:0];
      c = t[ByteW];
      ovf[i] = (a[ByteW*i+ByteW-1] == bb[ByteW*i+ByteW-1]) &&
               (t[ByteW-1] != a[ByteW*i+ByteW-1]);
    end
    return r;
  endfunction

  function automatic logic [DataW-1:0] laneSat(
    input logic [DataW-1:0] r, input logic [DataW-1:0] a,
    input logic [NumBytes-1:0] ovf, input logic c16, input logic c8);
    logic [DataW-1:0] o;
    logic neg;
    int t;
    for (int i = 0; i < NumBytes; i++) begin
      t = laneTop(i, c16, c8);
      neg = a[ByteW*t+ByteW-1];
      if (!ovf[t])     o[ByteW*i +: ByteW] = r[ByteW*i +: ByteW];
      else if (i == t) o[ByteW*i +: ByteW] = neg ? 8'h80 : 8'h7F;
      else             o[ByteW*i +: ByteW] = neg ? 8'h00 : 8'hFF;
    end
    return o;
  endfunction

  function automatic logic [ByteW-1:0] narrow(input logic [HalfW-1:0] h, input logic sat);
    if (sat && (h[HalfW-1:ByteW-1] != '0) && (h[HalfW-1:ByteW-1] != '1))
      return h[HalfW-1] ? 8'h80 : 8'h7F;
    return h[ByteW-1:0];
  endfunction

  logic [NumBytes-1:0] ovfSum, ovfDiff;
  logic [DataW-1:0] sumV, diffV, sumSel, diffSel, minV, maxV, unpV, packV;
  logic [DataW-1:0] nextA, nextB;
  logic [HalfW-1:0] unpSrc;

  always_comb begin
    sumV  = laneAdd(srcA, srcB, 1'b0, ctl.cut16, ctl.cut8, ovfSum);
    diffV = laneAdd(srcA, srcB, 1'b1, ctl.cut16, ctl.cut8, ovfDiff);
    sumSel  = ctl.doSat ? laneSat(sumV, srcA, ovfSum, ctl.cut16, ctl.cut8) : sumV;
    diffSel = ctl.doSat ? laneSat(diffV, srcA, ovfDiff, ctl.cut16, ctl.cut8) : diffV;
  end

  // Signed A<B per lane: sign of A-B corrected by its overflow.
  always_comb begin
    logic lt;
    int t;
    for (int i = 0; i < NumBytes; i++) begin
      t = laneTop(i, ctl.cut16, ctl.cut8);
      lt = diffV[ByteW*t+ByteW-1] ^ ovfDiff[t];
      minV[ByteW*i +: ByteW] = lt ? srcA[ByteW*i +: ByteW] : srcB[ByteW*i +: ByteW];
      maxV[ByteW*i +: ByteW] = lt ? srcB[ByteW*i +: ByteW] : srcA[ByteW*i +: ByteW];
    end
  end

  always_comb begin
    unpSrc = ctl.unpackHigh ? srcA[DataW-1:HalfW] : srcA[HalfW-1:0];
    for (int j = 0; j < 2; j++) begin
      unpV[HalfW*j +: HalfW] = {{ByteW{ctl.unpackSigned & unpSrc[ByteW*j+ByteW-1]}},
                                unpSrc[ByteW*j +: ByteW]};
      packV[ByteW*j +: ByteW]     = narrow(srcA[HalfW*j +: HalfW], ctl.packSat);
      packV[ByteW*(j+2) +: ByteW] = narrow(srcB[HalfW*j +: HalfW], ctl.packSat);
    end
  end

  always_comb begin
    if (ctl.pair)        nextA = sumSel;
    else if (ctl.arith)  nextA = ctl.doSub ? diffSel : sumSel;
    else if (ctl.doMin)  nextA = minV;
    else if (ctl.doMax)  nextA = maxV;
    else if (ctl.unpack) nextA = unpV;
    else if (ctl.pack)   nextA = packV;
    else                 nextA = '0;
    nextB = ctl.pair ? diffSel : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resA <= '0;
      resB <= '0;
    end else if (inValid) begin
      resA <= nextA;
      resB <= nextB;
    end
  end

  a_r5_second_port_idle: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !ctl.pair |=> resB == '0);
  a_r4_pos_sat_stays_pos: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ctl.arith && ctl.doSat && !ctl.doSub && !ctl.cut16 && !ctl.cut8 &&
    !srcA[DataW-1] && !srcB[DataW-1] |=> !resA[DataW-1]);
  a_r6_min_picks_source: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ctl.doMin && !ctl.cut16 && !ctl.cut8 |=>
    (resA == $past(srcA)) || (resA == $past(srcB)));
  a_r7_zero_extend: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ctl.unpack && !ctl.unpackSigned |=>
    (resA[HalfW-1:ByteW] == '0) && (resA[DataW-1:DataW-ByteW] == '0));
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [3:0]  opCode,
  input  logic [1:0]  laneMode,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  output logic        outValid,
  output logic [31:0] resA,
  output logic [31:0] resB
);
  ctrlT ctl;

  simd_alu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .laneMode(laneMode), .ctl(ctl), .outValid(outValid)
  );

  simd_alu_dp dp_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctl(ctl),
    .srcA(srcA), .srcB(srcB), .resA(resA), .resB(resB)
  );

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> !outValid && resA == '0 && resB == '0);
endmodule

// File: tb/simd_alu_tb_top.sv
`timescale 1ns/1ps
module simd_alu_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [1:0] laneMode = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic outValid;
  logic [31:0] resA, resB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] lastA, lastB;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  simd_alu dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode), .laneMode(laneMode),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .resA(resA), .resB(resB)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic longint sx(input longint v, input int w);
    if (v[w-1]) return v - (longint'(1) << w);
    return v;
  endfunction

  function automatic longint clampL(input longint v, input longint lo, input longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic string reqOf(input int op, input int mode);
    if (op >= 14 || (mode == 3 && op <= 7)) return "R9";
    if (op <= 1) return "R3";
    if (op <= 3) return "R4";
    if (op <= 5) return "R5";
    if (op <= 7) return "R6";
    if (op <= 11) return "R7";
    return "R8";
  endfunction

  function automatic void refModel(input int op, input int mode, input logic [31:0] a,
                                   input logic [31:0] b, output logic [31:0] ea,
                                   output logic [31:0] eb);
    int w;
    longint msk, lo, hi, sa, sb, r, r2;
    logic [15:0] sel;
    ea = '0;
    eb = '0;
    w = (mode == 1) ? 16 : (mode == 2) ? 8 : 32;
    msk = (longint'(1) << w) - 1;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -hi - 1;
    if (op <= 7) begin
      for (int k = 0; k < 32 / w; k++) begin
        sa = sx((longint'(a) >> (k * w)) & msk, w);
        sb = sx((longint'(b) >> (k * w)) & msk, w);
        r2 = 0;
        case (op)
          0: r = sa + sb;
          1: r = sa - sb;
          2: r = clampL(sa + sb, lo, hi);
          3: r = clampL(sa - sb, lo, hi);
          4: begin r = sa + sb; r2 = sa - sb; end
          5: begin r = clampL(sa + sb, lo, hi); r2 = clampL(sa - sb, lo, hi); end
          6: r = (sa < sb) ? sa : sb;
          default: r = (sa > sb) ? sa : sb;
        endcase
        ea = ea | 32'((r & msk) << (k * w));
        eb = eb | 32'((r2 & msk) << (k * w));
      end
    end else if (op <= 11) begin
      sel = (op == 9 || op == 11) ? a[31:16] : a[15:0];
      for (int j = 0; j < 2; j++) begin
        if (op >= 10) ea[16*j +: 16] = 16'(sx(longint'(sel[8*j +: 8]), 8));
        else          ea[16*j +: 16] = {8'h00, sel[8*j +: 8]};
      end
    end else if (op <= 13) begin
      for (int j = 0; j < 4; j++) begin
        r = sx(longint'(j < 2 ? a[16*j +: 16] : b[16*(j-2) +: 16]), 16);
        if (op == 13) r = clampL(r, -128, 127);
        ea[8*j +: 8] = 8'(r & 255);
      end
    end
  endfunction

  task automatic apply(input int op, input int mode, input logic [31:0] a,
                       input logic [31:0] b);
    logic [31:0] ea, eb;
    string req;
    @(negedge clk);
    inValid = 1'b1;
    opCode = 4'(op);
    laneMode = 2'(mode);
    srcA = a;
    srcB = b;
    @(posedge clk);
    #1;
    refModel(op, mode, a, b, ea, eb);
    req = reqOf(op, mode);
    chk(req, "resA", resA, ea);
    chk(op == 4 || op == 5 ? req : "R5", "resB", resB, eb);
    chk("R2", "outValid", outValid, 32'd1);
    lastA = ea;
    lastB = eb;
  endtask

  task automatic idleCheck();
    @(negedge clk);
    inValid = 1'b0;
    srcA = ~srcA;
    @(posedge clk);
    #1;
    chk("R2", "outValid idle", {31'd0, outValid}, 32'd0);
    chk("R2", "resA hold", resA, lastA);
    chk("R2", "resB hold", resB, lastB);
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  logic [31:0] corners [10] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h7F7F_7F7F, 32'h8080_8080, 32'h7FFF_8000,
    32'h00FF_01FE, 32'h8001_7FFE};

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "outValid reset", {31'd0, outValid}, 32'd0);
    chk("R1", "resA reset", resA, 32'd0);
    chk("R1", "resB reset", resB, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // Edge-word cross product for every opcode and lane mode (R3..R9)
    for (int op = 0; op < 16; op++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++)
            apply(op, mode, corners[i], corners[j]);
        for (int n = 0; n < 40; n++) begin
          logic [31:0] ra;
          lfsr = nextRand(lfsr);
          ra = lfsr;
          lfsr = nextRand(lfsr);
          apply(op, mode, ra, lfsr);
        end
        idleCheck();
      end
    end

    // Byte stride sweep with distinct bytes: carry cuts in 8/16-bit lanes (R3, R4)
    for (int op = 0; op < 8; op++) begin
      for (int x = 0; x < 256; x += 15) begin
        for (int y = 0; y < 256; y += 15) begin
          logic [7:0] bx, by;
          bx = 8'(x);
          by = 8'(y);
          apply(op, 2, {bx, bx ^ 8'h55, ~bx, bx + 8'd1}, {by, ~by, by ^ 8'hA3, by});
          apply(op, 1, {bx, ~bx, bx, bx ^ 8'h80}, {by, by, ~by, by});
        end
      end
    end
    idleCheck();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule